// File: doc/BRIEF.md
# Timer Event Generation and Status Flags

This block is the event and flag core of a small up-counting timer with two capture/compare channels. It owns a prescaler counter, the main counter, one capture register per channel and a six-bit flag set. Software reaches it through a single-cycle register write port with a select line. One target is an event word whose bits fire one-shot actions and clear themselves at once. The other target is a status word whose flags are cleared by writing 0 to them.

Each action takes effect on the clock edge that accepts the write. The actions are: reinitialising the counter and prescaler, forcing a channel event, and raising the trigger flag. An external strobe from trigger logic outside the block can also reinitialise the counter.

The update flag responds differently to its sources. A counter wrap sets it unless updates are disabled. A software or trigger reinitialisation sets it only when updates are enabled and the request-source select is 0. A channel in input mode copies the counter into its capture register when its event fires, and records an overcapture if its flag was still pending.

The write port carries no stream. It takes a plain strobe with no ready line and never stalls. Every write with `wr_en` high is acted on in that cycle.

Top module: `tmr_evt_top`

## Requirements
- R1: After reset the counter, both capture registers, all status bits and `irq` are 0.
- R2: An event write (`wr_sel`=0) acts only on bit 0 (update), bit 1 (channel 1 event), bit 2 (channel 2 event) and bit 6 (trigger). Each set bit gives exactly one action at the accepting edge. Zero bits and bits 3..5 and 7..15 have no effect.
- R3: An update event clears the counter and the prescaler counter at the accepting edge. The ratio is kept, so the next increment comes `psc_ratio`+1 enabled cycles later.
- R4: With `cnt_en`=1 the counter advances once every `psc_ratio`+1 cycles and wraps from `arr` to 0. That wrap sets status bit 0 (update flag) only when `upd_dis`=0.
- R5: An update event or a `trig_reinit` pulse always clears the counter. It sets status bit 0 only when `upd_src`=0 and `upd_dis`=0.
- R6: A trigger event sets status bit 3 (trigger flag).
- R7: With `ch_in_mode[i]`=0 (output), channel i's event sets status bit 1+i and leaves its capture register unchanged.
- R8: With `ch_in_mode[i]`=1 (input), channel i's event loads the counter value from the accepting cycle into its capture register and sets status bit 1+i. If that bit was already 1, it also sets status bit 4+i (overcapture).
- R9: A status write (`wr_sel`=1) clears every flag bit 0..5 written as 0 and keeps those written as 1. A hardware set in the same cycle wins over the clear.
- R10: `irq` is the OR over bits 0..3 of status AND `irq_en`, with `irq_en` bit order update, channel 1, channel 2, trigger. The overcapture bits never drive `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: event word, 1: status word |
| wr_data | input | 16 | Write data |
| cnt_en | input | 1 | Counting enable |
| psc_ratio | input | PSC_W | Prescaler ratio (divide by value+1) |
| arr | input | CNT_W | Auto-reload (wrap) value |
| upd_dis | input | 1 | Disable update flag setting |
| upd_src | input | 1 | 1: only wraps set the update flag |
| ch_in_mode | input | 2 | Per-channel mode, 1 = input/capture |
| irq_en | input | 4 | Interrupt enables |
| trig_reinit | input | 1 | External counter reinit strobe |
| cnt_val | output | CNT_W | Current counter value |
| cap1_val | output | CNT_W | Channel 1 capture register |
| cap2_val | output | CNT_W | Channel 2 capture register |
| status | output | 16 | Flags in bits 0..5, upper bits 0 |
| irq | output | 1 | Interrupt request |

## Verification
A prescaler that is left uncleared, or a wrong wrap compare, puts `cnt_val` off from the expected quotient within one prescale period after an update event. The first overflow flag then also appears early or late by exactly that offset. A wrong flag-gating or set/clear priority shows on `status` one edge after the offending write or strobe. A capture taken one cycle late shows as a value off by one in the capture register right after the event. Because `irq` is combinational from the flags, a wrong enable mapping shows in the same cycle that `irq_en` changes.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int WORD_W = 16;
  localparam int NCH    = 2;
  // event word bit positions (software-visible)
  localparam int EV_UPD = 0;
  localparam int EV_CC0 = 1;
  localparam int EV_TRG = 6;
  // status word bit positions
  localparam int ST_UPD  = 0;
  localparam int ST_CC0  = 1;
  localparam int ST_TRG  = 3;
  localparam int ST_OVC0 = 4;
  localparam int NFLAG   = 6;
  localparam int NIRQ    = 4;

  typedef struct packed {
    logic           upd;
    logic           trg;
    logic [NCH-1:0] cc;
  } evt_t;
endpackage

// File: rtl/tmr_evt_decode.sv
module tmr_evt_decode
  import tmr_evt_pkg::*;
(
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output evt_t              evt,
  output logic [NFLAG-1:0]  sts_clr
);
  logic evt_wr, sts_wr;
  logic unused_rsvd;

  assign evt_wr = wr_en && !wr_sel;
  assign sts_wr = wr_en && wr_sel;

  always_comb begin
    evt.upd = evt_wr && wr_data[EV_UPD];
    evt.trg = evt_wr && wr_data[EV_TRG];
    for (int i = 0; i < NCH; i++) evt.cc[i] = evt_wr && wr_data[EV_CC0+i];
    for (int f = 0; f < NFLAG; f++) sts_clr[f] = sts_wr && !wr_data[f];
  end

  assign unused_rsvd = ^wr_data[WORD_W-1:EV_TRG+1];
endmodule

// File: rtl/tmr_evt_counter.sv
module tmr_evt_counter #(
  parameter int CNT_W = 8,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             reinit,
  input  logic [PSC_W-1:0] psc_ratio,
  input  logic [CNT_W-1:0] arr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf
);
  logic [PSC_W-1:0] psc_q;
  logic             psc_hit;

  assign psc_hit = psc_q >= psc_ratio;
  assign ovf     = cnt_en && !reinit && psc_hit && (cnt_q >= arr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_q <= '0;
      cnt_q <= '0;
    end else if (reinit) begin
      psc_q <= '0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      if (psc_hit) begin
        psc_q <= '0;
        cnt_q <= (cnt_q >= arr) ? '0 : cnt_q + CNT_W'(1);
      end else begin
        psc_q <= psc_q + PSC_W'(1);
      end
    end
  end

  assert_reinit_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (cnt_q == '0) && (psc_q == '0));

  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt_q == '0);
endmodule

// File: rtl/tmr_evt_capture.sv
module tmr_evt_capture #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [CNT_W-1:0] cnt_in,
  output logic [CNT_W-1:0] cap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= cnt_in;
  end

  assert_capture_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> cap_q == $past(cnt_in));

  assert_capture_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(cap_q));
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr) | set;
  end

  for (genvar i = 0; i < NF; i++) begin : g_chk
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag_q[i]);
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !flag_q[i]);
  end
endmodule

// File: rtl/tmr_evt_top.sv
module tmr_evt_top
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PSC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              cnt_en,
  input  logic [PSC_W-1:0]  psc_ratio,
  input  logic [CNT_W-1:0]  arr,
  input  logic              upd_dis,
  input  logic              upd_src,
  input  logic [NCH-1:0]    ch_in_mode,
  input  logic [NIRQ-1:0]   irq_en,
  input  logic              trig_reinit,
  output logic [CNT_W-1:0]  cnt_val,
  output logic [CNT_W-1:0]  cap1_val,
  output logic [CNT_W-1:0]  cap2_val,
  output logic [WORD_W-1:0] status,
  output logic              irq
);
  evt_t             evt;
  logic [NFLAG-1:0] sts_clr, sts_set, sts_q;
  logic             reinit, ovf;
  logic [NCH-1:0]   cap_en;
  logic [CNT_W-1:0] cap_arr [NCH];

  tmr_evt_decode u_dec (
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .evt(evt), .sts_clr(sts_clr)
  );

  assign reinit = evt.upd || trig_reinit;

  tmr_evt_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .reinit(reinit),
    .psc_ratio(psc_ratio), .arr(arr), .cnt_q(cnt_val), .ovf(ovf)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cap_en[i] = evt.cc[i] && ch_in_mode[i];
    tmr_evt_capture #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en[i]),
      .cnt_in(cnt_val), .cap_q(cap_arr[i])
    );

    assert_ovc_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q[ST_OVC0+i]) |-> $past(sts_q[ST_CC0+i]));
  end

  always_comb begin
    sts_set         = '0;
    sts_set[ST_UPD] = (ovf && !upd_dis) || (reinit && !upd_src && !upd_dis);
    sts_set[ST_TRG] = evt.trg;
    for (int i = 0; i < NCH; i++) begin
      sts_set[ST_CC0+i]  = evt.cc[i];
      sts_set[ST_OVC0+i] = cap_en[i] && sts_q[ST_CC0+i];
    end
  end

  tmr_evt_flags #(.NF(NFLAG)) u_flg (
    .clk(clk), .rst_n(rst_n), .set(sts_set), .clr(sts_clr), .flag_q(sts_q)
  );

  assign cap1_val = cap_arr[0];
  assign cap2_val = cap_arr[1];
  assign status   = {{(WORD_W-NFLAG){1'b0}}, sts_q};
  assign irq      = |(sts_q[NIRQ-1:0] & irq_en);

  assert_upd_dis_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(upd_dis) |-> !$rose(sts_q[ST_UPD]));
endmodule

// File: tb/tb_tmr_evt_top.sv
module tb_tmr_evt_top;
  localparam int CNT_W = 8;
  localparam int PSC_W = 8;

  logic             clk = 0, rst_n = 0;
  logic             wr_en = 0, wr_sel = 0;
  logic [15:0]      wr_data = '0;
  logic             cnt_en = 0, upd_dis = 0, upd_src = 0, trig_reinit = 0;
  logic [PSC_W-1:0] psc_ratio = '0;
  logic [CNT_W-1:0] arr = 8'd15;
  logic [1:0]       ch_in_mode = '0;
  logic [3:0]       irq_en = '0;
  logic [CNT_W-1:0] cnt_val, cap1_val, cap2_val;
  logic [15:0]      status;
  logic             irq;
  int checks = 0, failures = 0;

  tmr_evt_top #(.CNT_W(CNT_W), .PSC_W(PSC_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_en(cnt_en), .psc_ratio(psc_ratio), .arr(arr), .upd_dis(upd_dis),
    .upd_src(upd_src), .ch_in_mode(ch_in_mode), .irq_en(irq_en),
    .trig_reinit(trig_reinit), .cnt_val(cnt_val), .cap1_val(cap1_val),
    .cap2_val(cap2_val), .status(status), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 act=%0h exp=%0h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    chk("R1 cnt", cnt_val, 0);
    chk("R1 cap1", cap1_val, 0);
    chk("R1 cap2", cap2_val, 0);
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);

    // R2 reserved and zero bits do nothing
    wr(0, 16'hFFB8);
    chk("R2 reserved status", status, 0);
    chk("R2 reserved cnt", cnt_val, 0);
    wr(0, 16'h0000);
    chk("R2 zero status", status, 0);

    // R3/R4 counter sweep, only wraps set update flag (upd_src=1)
    upd_src = 1; upd_dis = 0;
    for (int p = 0; p < 4; p++) begin
      for (int a = 1; a < 5; a++) begin
        cnt_en = 0; psc_ratio = PSC_W'(p); arr = CNT_W'(a);
        wr(1, 16'h0000);
        wr(0, 16'h0001);
        cnt_en = 1;
        for (int k = 0; k <= 2*(p+1)*(a+1)+1; k++) begin
          chk("R3 R4 cnt", cnt_val, (k/(p+1)) % (a+1));
          chk("R4 upd flag", status[0], (k >= (p+1)*(a+1)) ? 1 : 0);
          @(negedge clk);
        end
      end
    end
    // R3 mid-prescale update: ratio kept
    psc_ratio = 3; arr = 15;
    step(2);
    wr(0, 16'h0001);
    chk("R3 cleared", cnt_val, 0);
    step(3);
    chk("R3 not yet", cnt_val, 0);
    step(1);
    chk("R3 first inc", cnt_val, 1);

    // R4 upd_dis blocks wrap flag
    cnt_en = 0; upd_dis = 1; psc_ratio = 0; arr = 2;
    wr(1, 16'h0000);
    cnt_en = 1;
    step(10);
    chk("R4 dis no flag", status[0], 0);
    cnt_en = 0;

    // R5 reinit sources vs gating
    arr = 15;
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 2; d++) begin
        for (int v = 0; v < 2; v++) begin
          upd_src = s[0]; upd_dis = d[0];
          cnt_en = 1; step(3); cnt_en = 0;
          wr(1, 16'h0000);
          if (v == 0) wr(0, 16'h0001);
          else begin trig_reinit = 1; step(1); trig_reinit = 0; end
          chk("R5 cnt cleared", cnt_val, 0);
          chk("R5 upd flag", status[0], (s == 0 && d == 0) ? 1 : 0);
        end
      end
    end

    // R6 trigger
    upd_src = 1; upd_dis = 0;
    wr(1, 16'h0000);
    wr(0, 16'h0040);
    chk("R6 trig flag", status, 16'h0008);
    step(2);
    chk("R2 one-shot", status, 16'h0008);

    // R7 output-mode channel events
    ch_in_mode = 2'b00;
    wr(1, 16'h0000);
    wr(0, 16'h0001);
    cnt_en = 1; step(5); cnt_en = 0;
    wr(0, 16'h0002);
    chk("R7 cc1 flag", status, 16'h0002);
    chk("R7 cap1 kept", cap1_val, 0);
    wr(0, 16'h0004);
    chk("R7 cc2 flag", status, 16'h0006);
    chk("R7 cap2 kept", cap2_val, 0);

    // R8 input-mode capture and overcapture
    ch_in_mode = 2'b11;
    for (int ch = 0; ch < 2; ch++) begin
      for (int n = 0; n < 8; n++) begin
        wr(1, 16'h0000);
        wr(0, 16'h0001);
        cnt_en = 1; step(n); cnt_en = 0;
        wr(0, 16'(1 << (1+ch)));
        chk("R8 cap value", (ch == 0) ? cap1_val : cap2_val, n);
        chk("R8 flag no ovc", status, 32'(1 << (1+ch)));
        wr(0, 16'(1 << (1+ch)));
        chk("R8 ovc set", status, 32'((1 << (1+ch)) | (1 << (4+ch))));
        chk("R8 cap again", (ch == 0) ? cap1_val : cap2_val, n);
      end
    end

    // R9 selective clear and set-wins
    ch_in_mode = 2'b00; upd_src = 0; upd_dis = 0;
    wr(1, 16'h0000);
    wr(0, 16'h0043);
    chk("R9 setup", status, 16'h000B);
    wr(1, 16'hFFFE);
    chk("R9 clear bit0 only", status, 16'h000A);
    wr(0, 16'h0001);
    trig_reinit = 1; wr(1, 16'h0000); trig_reinit = 0;
    chk("R9 set wins", status, 16'h0001);
    wr(1, 16'h0000);
    chk("R9 all cleared", status, 0);

    // R10 irq exhaustive over flags x enables
    for (int f = 0; f < 16; f++) begin
      wr(1, 16'h0000);
      if (f != 0) wr(0, 16'((f & 7) | ((f & 8) << 3)));
      chk("R10 flags", status, f);
      for (int e = 0; e < 16; e++) begin
        irq_en = 4'(e);
        #1;
        chk("R10 irq", irq, ((f & e) != 0) ? 1 : 0);
      end
      irq_en = 0;
      @(negedge clk);
    end
    // R10 overcapture alone raises no irq
    ch_in_mode = 2'b01;
    wr(1, 16'h0000);
    wr(0, 16'h0002);
    wr(0, 16'h0002);
    wr(1, 16'hFFF0);
    chk("R10 ovc only", status, 16'h0010);
    irq_en = 4'hF;
    #1;
    chk("R10 ovc no irq", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule